// File: doc/BRIEF.md
# Frequency-Aided PI Loop Filter

This block is the digital loop filter of a disciplined-oscillator control loop. It runs once for each reference tick. A tick arrives as a one-cycle `sample_valid` strobe that carries a signed phase-error word. For each tick the filter returns a signed tuning word for the oscillator's DAC.

The integrator takes two inputs side by side:

- an integral term, the scaled phase error;
- a frequency term, the scaled tick-to-tick difference of the phase error.

Because the frequency term lives in the integrator, a large initial frequency offset is pulled in by the same linear update that later holds phase lock. No mode switch or hand-over is involved. The proportional term is added only at the output and never touches the stored state.

All three gains are arithmetic right shifts. The phase detector may have a modulus that is not a power of two. When it does, each phase difference is folded back into half a modulus on either side of zero before use. After reset the filter stays open and outputs a programmable centre word. It closes once the change in frequency between consecutive ticks is smaller than a programmable threshold. After that it stays closed until the next reset.

Top module: `fll_pi_filter`

## Requirements
- R1: While reset is asserted and after it is released, `ctrl_out` equals `centre`, and `out_valid` and `loop_closed` are 0.
- R2: `out_valid` is high for exactly one cycle, in the cycle after each `sample_valid`, and `ctrl_out` and `loop_closed` change only in that cycle.
- R3: Let f(n) = e(n) - e(n-1) be the frequency term of tick n. The first tick after reset produces no f, and the second produces no drift. Starting with the third tick, the drift f(n) - f(n-1) is compared with `drift_thr`. `loop_closed` becomes 1 with the output of the first such tick where |drift| < `drift_thr` (strict). Until the tick after that, `ctrl_out` stays at `centre`.
- R4: On each tick after the loop has closed, the integrator becomes its old value plus (e >>> `shift_i`) plus (f >>> `shift_f`). Shifts are arithmetic, by 0 to 31.
- R5: On a closed tick, `ctrl_out` = `centre` + integrator (after this tick's update) + (e >>> `shift_p`). The proportional term never enters the integrator.
- R6: If `phase_mod` is 0, f is the 32-bit two's-complement wrapping difference. Otherwise, let h = `phase_mod` >> 1. The raw difference d is replaced by d - `phase_mod` when d >= h, and by d + `phase_mod` when d < -h.
- R7: The integrator and `ctrl_out` are each clamped to the signed 20-bit range [-524288, 524287].
- R8: If the sum that formed the previous `ctrl_out` fell outside the 20-bit range, the integrator holds its value on the next tick.
- R9: Once set, `loop_closed` stays 1 until reset, whatever the drift does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | One-cycle strobe per reference tick |
| phase_err | input | 32 | Signed phase error of this tick |
| phase_mod | input | 32 | Detector modulus; 0 means binary wrap |
| shift_p | input | 5 | Proportional gain shift |
| shift_i | input | 5 | Integral gain shift |
| shift_f | input | 5 | Frequency-term gain shift |
| drift_thr | input | 32 | Unsigned closing threshold on drift magnitude |
| centre | input | 20 | Signed output while open and offset when closed |
| ctrl_out | output | 20 | Signed tuning word |
| out_valid | output | 1 | Pulse marking a new `ctrl_out` |
| loop_closed | output | 1 | Loop has closed since reset |

## Verification
The hardest condition to reach is the tick right after a saturated output. The clamp has to be active, and the next frequency term has to pull hard in the opposite direction, so that a held integrator and a free-running one give visibly different outputs. The bench first closes the loop with zero errors. It then applies a phase step large enough to overflow both the integrator and the output, and follows it with a zero sample whose negative frequency term would drag an unfrozen integrator well inside the range. A separate sequence steps across the detector modulus, where a missing fold would turn a small frequency term into one near the full modulus.

// File: rtl/fll_pi_filter.sv
module fll_pi_filter #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 20,
  parameter int GUARD = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_valid,
  input  logic signed [IN_W-1:0]  phase_err,
  input  logic [IN_W-1:0]         phase_mod,
  input  logic [4:0]              shift_p,
  input  logic [4:0]              shift_i,
  input  logic [4:0]              shift_f,
  input  logic [IN_W-1:0]         drift_thr,
  input  logic signed [OUT_W-1:0] centre,
  output logic signed [OUT_W-1:0] ctrl_out,
  output logic                    out_valid,
  output logic                    loop_closed
);

  localparam int ACC_W = IN_W + GUARD;
  localparam int FW    = IN_W + 1;
  localparam int DW    = IN_W + 2;
  localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = ~MAXV;

  logic signed [IN_W-1:0]  prev_e;
  logic signed [FW-1:0]    prev_f;
  logic signed [OUT_W-1:0] integ;
  logic [1:0]              seen;
  logic                    sat_q;

  function automatic logic signed [OUT_W-1:0] clamp(input logic signed [ACC_W-1:0] v);
    if (v > MAXV)      return MAXV[OUT_W-1:0];
    else if (v < MINV) return MINV[OUT_W-1:0];
    else               return v[OUT_W-1:0];
  endfunction

  // frequency term with optional modulus fold
  logic signed [IN_W-1:0] bin_diff;
  logic signed [FW-1:0]   raw_d, half, modx, freq;
  assign bin_diff = phase_err - prev_e;
  assign raw_d    = {phase_err[IN_W-1], phase_err} - {prev_e[IN_W-1], prev_e};
  assign modx     = {1'b0, phase_mod};
  assign half     = {2'b0, phase_mod[IN_W-1:1]};

  always_comb begin
    if (phase_mod == '0)  freq = {bin_diff[IN_W-1], bin_diff};
    else if (raw_d >= half) freq = raw_d - modx;
    else if (raw_d < -half) freq = raw_d + modx;
    else                    freq = raw_d;
  end

  // drift gate
  logic signed [DW-1:0] drift, drift_mag;
  logic                 close_now;
  assign drift     = {freq[FW-1], freq} - {prev_f[FW-1], prev_f};
  assign drift_mag = drift[DW-1] ? -drift : drift;
  assign close_now = (seen == 2'd2) && (drift_mag < $signed({2'b0, drift_thr}));

  // gain terms
  logic signed [ACC_W-1:0] e_x, f_x, p_term, i_term, f_term;
  assign e_x    = {{(ACC_W-IN_W){phase_err[IN_W-1]}}, phase_err};
  assign f_x    = {{(ACC_W-FW){freq[FW-1]}}, freq};
  assign p_term = e_x >>> shift_p;
  assign i_term = e_x >>> shift_i;
  assign f_term = f_x >>> shift_f;

  logic signed [ACC_W-1:0] integ_x, integ_sum, out_sum;
  logic signed [OUT_W-1:0] integ_nxt;
  assign integ_x   = {{(ACC_W-OUT_W){integ[OUT_W-1]}}, integ};
  assign integ_sum = integ_x + i_term + f_term;
  assign integ_nxt = sat_q ? integ : clamp(integ_sum);
  assign out_sum   = {{(ACC_W-OUT_W){centre[OUT_W-1]}}, centre}
                   + {{(ACC_W-OUT_W){integ_nxt[OUT_W-1]}}, integ_nxt} + p_term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_e      <= '0;
      prev_f      <= '0;
      integ       <= '0;
      seen        <= '0;
      sat_q       <= 1'b0;
      loop_closed <= 1'b0;
      out_valid   <= 1'b0;
      ctrl_out    <= centre;
    end else begin
      out_valid <= sample_valid;
      if (sample_valid) begin
        prev_e <= phase_err;
        if (seen != 2'd0) prev_f <= freq;
        if (seen != 2'd2) seen <= seen + 2'd1;
        if (loop_closed) begin
          integ    <= integ_nxt;
          ctrl_out <= clamp(out_sum);
          sat_q    <= (out_sum > MAXV) || (out_sum < MINV);
        end else begin
          ctrl_out <= centre;
          sat_q    <= 1'b0;
          if (close_now) loop_closed <= 1'b1;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> out_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> !out_valid); // R2
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(ctrl_out)); // R2
  AST_OPEN_CENTRE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !loop_closed) |-> (ctrl_out == centre)); // R3
  AST_STICKY_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    loop_closed |=> loop_closed); // R9
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && sat_q) |=> $stable(integ)); // R8
  AST_OPEN_NO_INT: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_closed |-> (integ == '0)); // R3

endmodule

// File: tb/sim_fll_pi_filter.sv
`timescale 1ns/1ps
module sim_fll_pi_filter;
  logic clk = 0, rst_n = 0, sample_valid = 0;
  logic signed [31:0] phase_err = 0;
  logic [31:0] phase_mod = 0, drift_thr = 0;
  logic [4:0] shift_p = 0, shift_i = 0, shift_f = 0;
  logic signed [19:0] centre = 0;
  logic signed [19:0] ctrl_out;
  logic out_valid, loop_closed;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fll_pi_filter u0 (.clk, .rst_n, .sample_valid, .phase_err, .phase_mod,
    .shift_p, .shift_i, .shift_f, .drift_thr, .centre,
    .ctrl_out, .out_valid, .loop_closed);

  localparam int N = 7;
  localparam int TE[N] = '{8, 12, 16, 20, 20, -8, -7};
  localparam int TX[N] = '{100, 100, 100, 119, 124, 80, 79};
  localparam int TC[N] = '{0, 0, 1, 1, 1, 1, 1};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [31:0] m, input logic [31:0] thr,
                          input int sp, input int si, input int sf, input int c);
    @(negedge clk);
    rst_n = 0; phase_mod = m; drift_thr = thr;
    shift_p = 5'(sp); shift_i = 5'(si); shift_f = 5'(sf); centre = 20'(c);
    repeat (3) @(negedge clk);
    chk("R1 ctrl_out in reset", ctrl_out, c);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ctrl_out after reset", ctrl_out, c);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 loop_closed after reset", loop_closed, 0);
  endtask

  task automatic tick(input string req, input int e, input int exp, input int cl);
    @(negedge clk);
    sample_valid = 1; phase_err = e;
    @(negedge clk);
    sample_valid = 0;
    chk("R2 out_valid pulse", out_valid, 1);
    chk(req, ctrl_out, exp);
    chk("R3/R9 loop_closed", loop_closed, cl);
    @(negedge clk);
    chk("R2 out_valid single cycle", out_valid, 0);
    chk("R2 ctrl_out held", ctrl_out, exp);
  endtask

  initial begin
    // main table: R3 R4 R5 R9 (s6 has drift -28 yet stays closed)
    do_reset(0, 5, 1, 2, 0, 100);
    for (int k = 0; k < N; k++) tick("R4/R5 table ctrl_out", TE[k], TX[k], TC[k]);

    // R3: large drift keeps loop open until it settles
    do_reset(0, 5, 0, 0, 0, 100);
    tick("R3 first", 0, 100, 0);
    tick("R3 second", 100, 100, 0);
    tick("R3 drift too large", 300, 100, 0);
    tick("R3 drift settles", 500, 100, 1);
    tick("R4 first closed tick", 700, 100 + 900 + 700, 1);

    // R6: modulus 1000 fold across the wrap
    do_reset(1000, 1000, 31, 31, 0, 100);
    tick("R6 s1", 480, 100, 0);
    tick("R6 s2", 490, 100, 0);
    tick("R6 s3", 495, 100, 1);
    tick("R6 folded difference", -497, 106, 1);
    tick("R6 after wrap", -490, 112, 1);

    // R7 R8: saturation and freeze
    do_reset(0, 32'h7fffffff, 0, 0, 0, 0);
    tick("R7 s1", 0, 0, 0);
    tick("R7 s2", 0, 0, 0);
    tick("R7 s3", 0, 0, 1);
    tick("R7 positive clamp", 600000, 524287, 1);
    tick("R8 integrator frozen", 0, 524287, 1);
    tick("R8 integrator free again", 0, 524287, 1);
    tick("R7 negative clamp", -2000000, -524288, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule